// File: doc/BRIEF.md
# CAN Controller Status Byte

This block holds the read-only status byte that a host CPU sees from a CAN protocol controller. The protocol engine reports events as single-cycle strobes: a frame transmission starts or ends, a transmission completes successfully, a reception starts or ends, and a received message is accepted for storage. The engine also supplies the live transmit and receive error counters and its bus-off state. The host issues three command strobes: request a transmission, release a receive buffer, and clear the overrun flag.

Internally the block counts how many of the two receive buffers are occupied. It also tracks whether the single transmit buffer is locked. A host write to the transmit buffer while it is locked is refused and flagged. A read at address 2 returns the status byte one clock later. Reads at any other address return zero.

Status byte layout: bit 7 bus-off, bit 6 error warning, bit 5 transmitting, bit 4 receiving, bit 3 transmission complete, bit 2 transmit buffer released, bit 1 data overrun, bit 0 receive buffer holds a message.

Top module: `can_status_reg`

## Requirements
- R1: After synchronous reset the status byte reads 0x0C: bus-on, no warning, both activity bits idle, transmission complete 1, transmit buffer released, no overrun, receive buffers empty.
- R2: A read with `rd_en_i` high and `rd_addr_i` equal to 2 places the status byte on `rd_data_o` at the next clock edge, using the bit layout above. Any other read, or no read, gives 0x00 on that edge.
- R3: Bit 7 equals `bus_off_i`.
- R4: Bit 6 is 1 when either error counter is 96 or more. It is 0 when both counters are 95 or less.
- R5: Bit 5 is set by `tx_start_i` and cleared by `tx_end_i`. When both arrive in the same cycle, it is set.
- R6: Bit 4 is set by `rx_start_i` and cleared by `rx_end_i`. When both arrive in the same cycle, it is set.
- R7: `cmd_tx_req_i` while the transmit buffer is released locks it (bit 2 goes to 0) and clears bit 3.
- R8: `tx_ok_i` while the transmit buffer is locked releases it (bit 2 goes to 1) and sets bit 3.
- R9: `cmd_tx_req_i` while locked has no effect. `txb_wr_i` while locked raises `txb_reject_o` for exactly one cycle. `txb_wr_i` while released raises no pulse.
- R10: `rx_accept_i` raises the buffer occupancy by one, up to 2. `cmd_rel_rx_i` lowers it by one. Bit 0 is 1 while the occupancy is nonzero.
- R11: `rx_accept_i` when both buffers are full sets bit 1 and leaves the occupancy at 2. A release in the same cycle is applied first, so an accept and a release together at occupancy 2 do not overrun.
- R12: Bit 1 is cleared only by `cmd_clr_ovr_i`. If an overrun occurs in the same cycle as the clear, bit 1 stays set.
- R13: `cmd_rel_rx_i` at occupancy 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start_i | input | 1 | Engine began sending a frame |
| tx_end_i | input | 1 | Engine stopped sending a frame |
| tx_ok_i | input | 1 | Requested transmission finished successfully |
| rx_start_i | input | 1 | Engine began receiving a frame |
| rx_end_i | input | 1 | Engine stopped receiving a frame |
| rx_accept_i | input | 1 | A received message is to be stored |
| bus_off_i | input | 1 | Controller is bus-off |
| tx_err_cnt_i | input | 8 | Transmit error counter |
| rx_err_cnt_i | input | 8 | Receive error counter |
| cmd_tx_req_i | input | 1 | Host transmit request |
| cmd_rel_rx_i | input | 1 | Host release receive buffer |
| cmd_clr_ovr_i | input | 1 | Host clear overrun |
| txb_wr_i | input | 1 | Host write attempt to the transmit buffer |
| txb_reject_o | output | 1 | One-cycle pulse: write refused because the buffer is locked |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench targets the error-warning threshold at 95 and 96 on each counter separately. A design with an off-by-one compare, or one that checks only one counter, reports the wrong bit 6. It also targets the same-cycle collisions: start with end, accept with release at full occupancy, and overrun with clear. A design that picks the wrong winner in any of these leaves a stale activity bit, raises a false overrun, or loses an overrun. It checks release at empty and accept at full, where a design without bounds on its occupancy count would wrap and report a wrong buffer-full bit afterwards. Finally, it checks that a write to a locked transmit buffer gives exactly one reject pulse and that a write to a released buffer gives none.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int BIT_BUSOFF = 7;
  localparam int BIT_WARN   = 6;
  localparam int BIT_TXACT  = 5;
  localparam int BIT_RXACT  = 4;
  localparam int BIT_TXDONE = 3;
  localparam int BIT_TXFREE = 2;
  localparam int BIT_OVR    = 1;
  localparam int BIT_RXFULL = 0;
  localparam int STAT_W     = 8;
endpackage

// File: rtl/can_act_flag.sv
module can_act_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
endmodule

// File: rtl/can_tx_track.sv
module can_tx_track (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ok_i,
  input  logic wr_i,
  output logic locked_o,
  output logic done_o,
  output logic reject_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b0;
      done_o   <= 1'b1;
      reject_o <= 1'b0;
    end else begin
      reject_o <= wr_i && locked_o;
      if (locked_o) begin
        if (ok_i) begin
          locked_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end else if (req_i) begin
        locked_o <= 1'b1;
        done_o   <= 1'b0;
      end
    end
  end

  p_req_locks_r7: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && req_i) |=> (locked_o && !done_o));
  p_ok_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (locked_o && ok_i) |=> (!locked_o && done_o));
  p_reject_single_r9: assert property (@(posedge clk) disable iff (rst)
    (reject_o && !(wr_i && locked_o)) |=> !reject_o);
endmodule

// File: rtl/can_rx_track.sv
module can_rx_track #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_i,
  input  logic rel_i,
  input  logic clr_i,
  output logic avail_o,
  output logic ovr_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt, eff, cnt_nxt;
  logic          full_eff;

  always_comb begin
    eff      = cnt - CW'(rel_i && (cnt != '0));
    full_eff = (eff == CW'(DEPTH));
    cnt_nxt  = eff + CW'(acc_i && !full_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ovr_o <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (acc_i && full_eff) ovr_o <= 1'b1;
      else if (clr_i)        ovr_o <= 1'b0;
    end
  end

  assign avail_o = (cnt != '0);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_full_acc_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH) && acc_i && !rel_i) |=> (ovr_o && cnt == CW'(DEPTH)));
  p_ovr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !clr_i) |=> ovr_o);
  p_rel_empty_r13: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && rel_i && !acc_i) |=> (cnt == '0));
endmodule

// File: rtl/can_status_reg.sv
module can_status_reg
  import can_stat_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int ADDR_W     = 3,
  parameter int STAT_ADDR  = 2,
  parameter int RX_BUFS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start_i,
  input  logic              tx_end_i,
  input  logic              tx_ok_i,
  input  logic              rx_start_i,
  input  logic              rx_end_i,
  input  logic              rx_accept_i,
  input  logic              bus_off_i,
  input  logic [CNT_W-1:0]  tx_err_cnt_i,
  input  logic [CNT_W-1:0]  rx_err_cnt_i,
  input  logic              cmd_tx_req_i,
  input  logic              cmd_rel_rx_i,
  input  logic              cmd_clr_ovr_i,
  input  logic              txb_wr_i,
  output logic              txb_reject_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [STAT_W-1:0] rd_data_o
);
  logic tx_act, rx_act, tx_locked, tx_done, rx_avail, rx_ovr, warn;
  logic [STAT_W-1:0] status;

  can_act_flag u_tx_act (.clk(clk), .rst(rst), .set_i(tx_start_i),
                         .clr_i(tx_end_i), .flag_o(tx_act));
  can_act_flag u_rx_act (.clk(clk), .rst(rst), .set_i(rx_start_i),
                         .clr_i(rx_end_i), .flag_o(rx_act));

  can_tx_track u_tx (.clk(clk), .rst(rst), .req_i(cmd_tx_req_i), .ok_i(tx_ok_i),
                     .wr_i(txb_wr_i), .locked_o(tx_locked), .done_o(tx_done),
                     .reject_o(txb_reject_o));

  can_rx_track #(.DEPTH(RX_BUFS)) u_rx (.clk(clk), .rst(rst), .acc_i(rx_accept_i),
                     .rel_i(cmd_rel_rx_i), .clr_i(cmd_clr_ovr_i),
                     .avail_o(rx_avail), .ovr_o(rx_ovr));

  always_comb begin
    warn = (tx_err_cnt_i >= CNT_W'(WARN_LIMIT)) || (rx_err_cnt_i >= CNT_W'(WARN_LIMIT));
    status             = '0;
    status[BIT_BUSOFF] = bus_off_i;
    status[BIT_WARN]   = warn;
    status[BIT_TXACT]  = tx_act;
    status[BIT_RXACT]  = rx_act;
    status[BIT_TXDONE] = tx_done;
    status[BIT_TXFREE] = !tx_locked;
    status[BIT_OVR]    = rx_ovr;
    status[BIT_RXFULL] = rx_avail;
  end

  always_ff @(posedge clk) begin
    if (rst)                                               rd_data_o <= '0;
    else if (rd_en_i && rd_addr_i == ADDR_W'(STAT_ADDR))   rd_data_o <= status;
    else                                                   rd_data_o <= '0;
  end

  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rd_data_o == '0));
  p_busoff_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == ADDR_W'(STAT_ADDR)) |=> (rd_data_o[BIT_BUSOFF] == $past(bus_off_i)));
endmodule

// File: tb/tb_can_status_reg.sv
module tb_can_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  localparam int E_TXS = 0, E_TXE = 1, E_TXOK = 2, E_RXS = 3, E_RXE = 4,
                 E_ACC = 5, E_REQ = 6, E_REL = 7, E_CLR = 8, E_WR = 9;

  logic [9:0] ev = '0;
  logic       bus_off = 1'b0;
  logic [7:0] tx_cnt = '0, rx_cnt = '0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic       reject;
  logic [7:0] rd_data;

  can_status_reg dut (
    .clk(clk), .rst(rst),
    .tx_start_i(ev[E_TXS]), .tx_end_i(ev[E_TXE]), .tx_ok_i(ev[E_TXOK]),
    .rx_start_i(ev[E_RXS]), .rx_end_i(ev[E_RXE]), .rx_accept_i(ev[E_ACC]),
    .bus_off_i(bus_off), .tx_err_cnt_i(tx_cnt), .rx_err_cnt_i(rx_cnt),
    .cmd_tx_req_i(ev[E_REQ]), .cmd_rel_rx_i(ev[E_REL]), .cmd_clr_ovr_i(ev[E_CLR]),
    .txb_wr_i(ev[E_WR]), .txb_reject_o(reject),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int total = 0, failed = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];
  logic       seen = 1'b0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [9:0] m);
    @(negedge clk) ev = m;
    @(negedge clk) ev = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) seen <= rd_en;

  always @(negedge clk) begin
    if (seen && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(rd_data, e, t);
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(3'd2, 8'h0C, "R1 reset value");
    rd(3'd3, 8'h00, "R2 other address");
    @(negedge clk) check(rd_data, 8'h00, "R2 idle read data");

    bus_off = 1'b1; rd(3'd2, 8'h8C, "R3 bus-off");
    bus_off = 1'b0; rd(3'd2, 8'h0C, "R3 bus-on");

    tx_cnt = 8'd95; rx_cnt = 8'd95; rd(3'd2, 8'h0C, "R4 both 95");
    rx_cnt = 8'd96; rd(3'd2, 8'h4C, "R4 rx 96");
    tx_cnt = 8'd96; rx_cnt = 8'd0; rd(3'd2, 8'h4C, "R4 tx 96");
    tx_cnt = 8'd0; rd(3'd2, 8'h0C, "R4 cleared");

    strobe(10'b1 << E_TXS); rd(3'd2, 8'h2C, "R5 tx start");
    strobe((10'b1 << E_TXS) | (10'b1 << E_TXE)); rd(3'd2, 8'h2C, "R5 start wins");
    strobe(10'b1 << E_TXE); rd(3'd2, 8'h0C, "R5 tx end");

    strobe(10'b1 << E_RXS); rd(3'd2, 8'h1C, "R6 rx start");
    strobe((10'b1 << E_RXS) | (10'b1 << E_RXE)); rd(3'd2, 8'h1C, "R6 start wins");
    strobe(10'b1 << E_RXE); rd(3'd2, 8'h0C, "R6 rx end");

    strobe(10'b1 << E_REQ); rd(3'd2, 8'h00, "R7 request locks");
    @(negedge clk) ev = 10'b1 << E_WR;
    @(negedge clk) begin ev = '0; check({7'd0, reject}, 8'h01, "R9 reject pulse"); end
    @(negedge clk) check({7'd0, reject}, 8'h00, "R9 pulse one cycle");
    strobe(10'b1 << E_REQ); rd(3'd2, 8'h00, "R9 request while locked");
    strobe(10'b1 << E_TXOK); rd(3'd2, 8'h0C, "R8 ok releases");
    @(negedge clk) ev = 10'b1 << E_WR;
    @(negedge clk) begin ev = '0; check({7'd0, reject}, 8'h00, "R9 no reject when free"); end

    strobe(10'b1 << E_ACC); rd(3'd2, 8'h0D, "R10 one buffer");
    strobe(10'b1 << E_ACC); rd(3'd2, 8'h0D, "R10 two buffers");
    strobe(10'b1 << E_ACC); rd(3'd2, 8'h0F, "R11 overrun when full");
    strobe(10'b1 << E_CLR); rd(3'd2, 8'h0D, "R12 clear overrun");
    strobe(10'b1 << E_REL); rd(3'd2, 8'h0D, "R10 release to one");
    strobe(10'b1 << E_REL); rd(3'd2, 8'h0C, "R10 release to empty");
    strobe(10'b1 << E_REL); rd(3'd2, 8'h0C, "R13 release at empty");
    strobe(10'b1 << E_ACC); rd(3'd2, 8'h0D, "R13 count not wrapped");

    strobe(10'b1 << E_ACC);
    strobe((10'b1 << E_ACC) | (10'b1 << E_REL)); rd(3'd2, 8'h0D, "R11 release first");
    strobe(10'b1 << E_REL); rd(3'd2, 8'h0D, "R11 still one left");
    strobe(10'b1 << E_REL); rd(3'd2, 8'h0C, "R11 count stayed two");

    strobe(10'b1 << E_ACC); strobe(10'b1 << E_ACC);
    strobe((10'b1 << E_ACC) | (10'b1 << E_CLR)); rd(3'd2, 8'h0F, "R12 set wins over clear");
    strobe(10'b1 << E_REL); strobe(10'b1 << E_REL);
    rd(3'd2, 8'h0E, "R12 overrun survives release");
    strobe(10'b1 << E_CLR); rd(3'd2, 8'h0C, "R12 clear command");

    repeat (3) @(negedge clk);
    report();
  end
endmodule